// File: doc/BRIEF.md
# Standby Mode Power Controller

This block sequences the low-power standby of a small microcontroller. It holds the standby-enable and watchdog-enable control bits, decides when a sleep strobe puts the chip into software standby, and qualifies the events that bring it back. While the chip sleeps, the oscillator is off, the clock gate is closed and the peripherals are held in reset. The block's own clock is a free-running reference that keeps running in standby. The register and RAM contents that must survive standby are kept elsewhere.

An enabled wake event restarts the oscillator and loads a settling counter. The counter length comes from a 3-bit select. When the count expires, the clocks return and a one-cycle interrupt-handling strobe is issued. A low reset pin brings the clocks back at once with no settling wait, and the reset-handling strobe follows when the pin is released. A low hardware-standby pin overrides everything. The only exit from hardware standby is to release that pin while reset is held low.

Top module: `stby_pwr_ctrl`

## Requirements
- R1: A sleep strobe moves the block from running to software standby only when the standby-enable bit reads 1; with the bit at 0 the clocks stay on and peripheral reset stays low.
- R2: In software standby, osc_en and clk_gate_en are 0 and periph_rst is 1; whenever clk_gate_en is 0, periph_rst is 1.
- R3: In software standby, NMI wakes the chip regardless of the enable bits and the global mask; an external request wakes it only when its own enable bit is 1 and irq_mask is 0. Ignored requests leave osc_en at 0.
- R4: The settling time in clocks, from the wake edge to the first cycle with clk_gate_en high, is set by settle_sel: code 0 gives 8192, 1 gives 16384, 2 gives 32768, 3 gives 65536, 4 gives 131072, 5 gives 1024, 6 gives 2048, and the reserved code 7 gives 2048. osc_en is 1 throughout the settling time.
- R5: When settling ends, clk_gate_en goes to 1 and irq_start is 1 for exactly that first running cycle.
- R6: A new rising edge of a qualified wake source during settling reloads the counter, so the full settling time counts again from that edge.
- R7: A low res_n (with hwstby_n high) turns on osc_en and clk_gate_en in the next cycle with no settling wait, aborts any settling count so that no irq_start follows, and keeps periph_rst high. rst_start pulses for one cycle in the cycle after res_n is sampled high.
- R8: A low hwstby_n forces hardware standby from any state in the next cycle: hw_stby is 1 and osc_en and clk_gate_en are 0.
- R9: Hardware standby persists while res_n is high, even after hwstby_n returns high; hwstby_n high with res_n low leads to the reset hold, where hw_stby is 0 and the clocks are on.
- R10: With wdt_wd_mode at 1, a write of 1 to the standby-enable bit is refused while the watchdog-enable bit is 1, and a write of 1 to the watchdog-enable bit is refused while the standby-enable bit is 1. When both writes of 1 arrive in the same cycle, the watchdog write wins. Writes of 0 and all writes with wdt_wd_mode at 0 are accepted.
- R11: irq_start and rst_start are never high for two cycles in a row and are never high while clk_gate_en is 0.
- R12: After power-on reset the block is running: osc_en=1, clk_gate_en=1, periph_rst=0, hw_stby=0, both strobes 0, both enable bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, active in standby |
| por_n | input | 1 | Active-low power-on reset of the block |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| stby_en_wr | input | 1 | Write strobe for the standby-enable bit |
| stby_en_d | input | 1 | Value written to the standby-enable bit |
| wdt_en_wr | input | 1 | Write strobe for the watchdog-enable bit |
| wdt_en_d | input | 1 | Value written to the watchdog-enable bit |
| wdt_wd_mode | input | 1 | Watchdog runs in watchdog (not interval) mode |
| settle_sel | input | 3 | Settling-time select code |
| nmi | input | 1 | Non-maskable interrupt request |
| irq_req | input | N_IRQ | External interrupt requests |
| irq_en | input | N_IRQ | Per-request enable bits |
| irq_mask | input | 1 | Global CPU interrupt mask |
| res_n | input | 1 | Active-low reset pin |
| hwstby_n | input | 1 | Active-low hardware-standby pin |
| osc_en | output | 1 | Oscillator enable |
| clk_gate_en | output | 1 | Chip clock gate open |
| periph_rst | output | 1 | Peripheral and DMA reset/halt |
| irq_start | output | 1 | One-cycle start of interrupt exception handling |
| rst_start | output | 1 | One-cycle start of reset exception handling |
| hw_stby | output | 1 | Hardware standby active |
| stby_en_q | output | 1 | Current standby-enable bit |
| wdt_en_q | output | 1 | Current watchdog-enable bit |

## Verification
A wrong state register shows at the ports in the very next cycle, because osc_en, clk_gate_en, periph_rst and hw_stby decode the state directly. Each of the five states has its own pattern on those outputs, except that software standby and hardware standby differ only in hw_stby. A corrupt settling counter shows only at the end of the wait, when clk_gate_en rises early or late. The bench therefore counts the exact number of gated cycles for several codes. A lost wake qualification shows as osc_en rising from a masked or disabled request within one cycle. A stale strobe register shows as a second irq_start or rst_start cycle, or as one while the gate is closed.

// File: rtl/stby_pkg.sv
package stby_pkg;

   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_SWSTBY  = 3'd1,
      ST_SETTLE  = 3'd2,
      ST_RSTHOLD = 3'd3,
      ST_HWSTBY  = 3'd4
   } pwr_state_e;

   localparam int unsigned SEL_W       = 3;
   localparam int unsigned MAX_SETTLE  = 131072;

   // Settling length in reference clocks for a select code, scaled down by shift.
   function automatic int unsigned settle_cycles(input logic [SEL_W-1:0] code,
                                                 input int unsigned      shift);
      int unsigned base;
      case (code)
         3'd0:    base = 8192;
         3'd1:    base = 16384;
         3'd2:    base = 32768;
         3'd3:    base = 65536;
         3'd4:    base = 131072;
         3'd5:    base = 1024;
         default: base = 2048;
      endcase
      base = base >> shift;
      if (base == 0) base = 1;
      return base;
   endfunction

endpackage

// File: rtl/stby_cfg_regs.sv
module stby_cfg_regs (
   input  logic clk,
   input  logic por_n,
   input  logic stby_en_wr,
   input  logic stby_en_d,
   input  logic wdt_en_wr,
   input  logic wdt_en_d,
   input  logic wdt_wd_mode,
   output logic stby_en_q,
   output logic wdt_en_q
);

   logic wdt_set_now;
   logic stby_block;
   logic wdt_block;

   // A watchdog write of 1 in this same cycle counts as already set.
   assign wdt_set_now = wdt_en_wr && wdt_en_d;
   assign stby_block  = stby_en_d && wdt_wd_mode && (wdt_en_q || wdt_set_now);
   assign wdt_block   = wdt_en_d  && wdt_wd_mode && stby_en_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         stby_en_q <= 1'b0;
         wdt_en_q  <= 1'b0;
      end else begin
         if (stby_en_wr && !stby_block) stby_en_q <= stby_en_d;
         if (wdt_en_wr && !wdt_block)   wdt_en_q  <= wdt_en_d;
      end
   end

endmodule

// File: rtl/stby_wake_qual.sv
module stby_wake_qual #(
   parameter int unsigned N_IRQ       = 3,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             nmi,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             irq_mask,
   output logic             wake_lvl,
   output logic             wake_evt
);

   localparam int unsigned RAW_W = N_IRQ + 1;

   logic [RAW_W-1:0] raw_src;
   logic [RAW_W-1:0] sync_src;
   logic [N_IRQ-1:0] irq_ok;
   logic             wake_q;

   assign raw_src = {irq_req, nmi};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sync_src = raw_src;
      end else begin : g_sync
         logic [RAW_W-1:0] stage_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               for (int s = 0; s < int'(SYNC_STAGES); s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= raw_src;
               for (int s = 1; s < int'(SYNC_STAGES); s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign sync_src = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < int'(N_IRQ); gi++) begin : g_irq
         assign irq_ok[gi] = sync_src[gi+1] && irq_en[gi] && !irq_mask;
      end
   endgenerate

   assign wake_lvl = sync_src[0] || (|irq_ok);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) wake_q <= 1'b0;
      else        wake_q <= wake_lvl;
   end

   assign wake_evt = wake_lvl && !wake_q;

endmodule

// File: rtl/stby_settle_timer.sv
module stby_settle_timer
   import stby_pkg::*;
#(
   parameter int unsigned CNT_W        = 17,
   parameter int unsigned SETTLE_SHIFT = 0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             load,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   assign load_val = CNT_W'(settle_cycles(sel, SETTLE_SHIFT) - 1);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                     cnt_q <= '0;
      else if (load)                  cnt_q <= load_val;
      else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = run && (cnt_q == '0);

endmodule

// File: rtl/stby_pwr_ctrl.sv
module stby_pwr_ctrl
   import stby_pkg::*;
#(
   parameter int unsigned N_IRQ        = 3,
   parameter int unsigned SYNC_STAGES  = 0,
   parameter int unsigned SETTLE_SHIFT = 0,
   parameter int unsigned CNT_W        = 17
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sleep_req,
   input  logic             stby_en_wr,
   input  logic             stby_en_d,
   input  logic             wdt_en_wr,
   input  logic             wdt_en_d,
   input  logic             wdt_wd_mode,
   input  logic [2:0]       settle_sel,
   input  logic             nmi,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             irq_mask,
   input  logic             res_n,
   input  logic             hwstby_n,
   output logic             osc_en,
   output logic             clk_gate_en,
   output logic             periph_rst,
   output logic             irq_start,
   output logic             rst_start,
   output logic             hw_stby,
   output logic             stby_en_q,
   output logic             wdt_en_q
);

   localparam int unsigned NEED_W = $clog2(MAX_SETTLE >> SETTLE_SHIFT) + 1;

   initial begin
      if (N_IRQ < 1 || N_IRQ > 16)
         $error("stby_pwr_ctrl: N_IRQ out of range");
      if (SETTLE_SHIFT > 10)
         $error("stby_pwr_ctrl: SETTLE_SHIFT too large");
      if (CNT_W + 1 < NEED_W)
         $error("stby_pwr_ctrl: CNT_W too narrow for settling counts");
      if (SYNC_STAGES > 4)
         $error("stby_pwr_ctrl: SYNC_STAGES too large");
   end

   pwr_state_e state_q, state_d;
   logic       wake_lvl, wake_evt;
   logic       cnt_load, cnt_done;
   logic       irq_start_d, rst_start_d;

   stby_cfg_regs u_cfg (
      .clk         (clk),
      .por_n       (por_n),
      .stby_en_wr  (stby_en_wr),
      .stby_en_d   (stby_en_d),
      .wdt_en_wr   (wdt_en_wr),
      .wdt_en_d    (wdt_en_d),
      .wdt_wd_mode (wdt_wd_mode),
      .stby_en_q   (stby_en_q),
      .wdt_en_q    (wdt_en_q)
   );

   stby_wake_qual #(.N_IRQ(N_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk      (clk),
      .por_n    (por_n),
      .nmi      (nmi),
      .irq_req  (irq_req),
      .irq_en   (irq_en),
      .irq_mask (irq_mask),
      .wake_lvl (wake_lvl),
      .wake_evt (wake_evt)
   );

   stby_settle_timer #(.CNT_W(CNT_W), .SETTLE_SHIFT(SETTLE_SHIFT)) u_timer (
      .clk   (clk),
      .por_n (por_n),
      .load  (cnt_load),
      .run   (state_q == ST_SETTLE),
      .sel   (settle_sel),
      .done  (cnt_done)
   );

   always_comb begin
      state_d  = state_q;
      cnt_load = 1'b0;
      if (!hwstby_n) begin
         state_d = ST_HWSTBY;
      end else begin
         case (state_q)
            ST_RUN: begin
               if (!res_n)                       state_d = ST_RSTHOLD;
               else if (sleep_req && stby_en_q)  state_d = ST_SWSTBY;
            end
            ST_SWSTBY: begin
               if (!res_n) begin
                  state_d = ST_RSTHOLD;
               end else if (wake_lvl) begin
                  state_d  = ST_SETTLE;
                  cnt_load = 1'b1;
               end
            end
            ST_SETTLE: begin
               if (!res_n)         state_d = ST_RSTHOLD;
               else if (wake_evt)  cnt_load = 1'b1;
               else if (cnt_done)  state_d = ST_RUN;
            end
            ST_RSTHOLD: begin
               if (res_n) state_d = ST_RUN;
            end
            ST_HWSTBY: begin
               if (!res_n) state_d = ST_RSTHOLD;
            end
            default: state_d = ST_RUN;
         endcase
      end
   end

   assign irq_start_d = (state_q == ST_SETTLE)  && (state_d == ST_RUN);
   assign rst_start_d = (state_q == ST_RSTHOLD) && (state_d == ST_RUN);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q   <= ST_RUN;
         irq_start <= 1'b0;
         rst_start <= 1'b0;
      end else begin
         state_q   <= state_d;
         irq_start <= irq_start_d;
         rst_start <= rst_start_d;
      end
   end

   assign osc_en      = (state_q == ST_RUN) || (state_q == ST_SETTLE) || (state_q == ST_RSTHOLD);
   assign clk_gate_en = (state_q == ST_RUN) || (state_q == ST_RSTHOLD);
   assign periph_rst  = (state_q != ST_RUN);
   assign hw_stby     = (state_q == ST_HWSTBY);

endmodule

// File: rtl/stby_pwr_ctrl_chk.sv
module stby_pwr_ctrl_chk #(
   parameter int unsigned N_IRQ = 3
) (
   input logic             clk,
   input logic             por_n,
   input logic             sleep_req,
   input logic             stby_en_wr,
   input logic             wdt_wd_mode,
   input logic             nmi,
   input logic [N_IRQ-1:0] irq_req,
   input logic [N_IRQ-1:0] irq_en,
   input logic             irq_mask,
   input logic             res_n,
   input logic             hwstby_n,
   input logic             osc_en,
   input logic             clk_gate_en,
   input logic             periph_rst,
   input logic             irq_start,
   input logic             rst_start,
   input logic             hw_stby,
   input logic             stby_en_q,
   input logic             wdt_en_q
);

   logic run_now;
   logic sw_now;
   assign run_now = clk_gate_en && !periph_rst;
   assign sw_now  = !osc_en && !hw_stby;

   assert_sleep_enter_R1: assert property (@(posedge clk) disable iff (!por_n)
      (run_now && res_n && hwstby_n && sleep_req && stby_en_q)
      |=> (!osc_en && !clk_gate_en && periph_rst && !hw_stby));

   assert_sleep_blocked_R1: assert property (@(posedge clk) disable iff (!por_n)
      (run_now && res_n && hwstby_n && !stby_en_q) |=> run_now);

   assert_gate_off_reset_R2: assert property (@(posedge clk) disable iff (!por_n)
      !clk_gate_en |-> periph_rst);

   assert_ignored_wake_R3: assert property (@(posedge clk) disable iff (!por_n)
      (sw_now && res_n && hwstby_n && !nmi && !(|(irq_req & irq_en & {N_IRQ{!irq_mask}})))
      |=> !osc_en);

   assert_reset_clocks_R7: assert property (@(posedge clk) disable iff (!por_n)
      (!res_n && hwstby_n) |=> (osc_en && clk_gate_en && periph_rst && !rst_start && !irq_start));

   assert_hw_override_R8: assert property (@(posedge clk) disable iff (!por_n)
      !hwstby_n |=> (hw_stby && !osc_en && !clk_gate_en));

   assert_hw_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
      (hw_stby && res_n) |=> hw_stby);

   assert_cfg_refuse_R10: assert property (@(posedge clk) disable iff (!por_n)
      (wdt_wd_mode && wdt_en_q && !stby_en_q && stby_en_wr) |=> !stby_en_q);

   assert_strobe_gated_R11: assert property (@(posedge clk) disable iff (!por_n)
      (irq_start || rst_start) |-> clk_gate_en);

   assert_irq_one_cycle_R11: assert property (@(posedge clk) disable iff (!por_n)
      irq_start |=> !irq_start);

   assert_rst_one_cycle_R11: assert property (@(posedge clk) disable iff (!por_n)
      rst_start |=> !rst_start);

endmodule

bind stby_pwr_ctrl stby_pwr_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .sleep_req   (sleep_req),
   .stby_en_wr  (stby_en_wr),
   .wdt_wd_mode (wdt_wd_mode),
   .nmi         (nmi),
   .irq_req     (irq_req),
   .irq_en      (irq_en),
   .irq_mask    (irq_mask),
   .res_n       (res_n),
   .hwstby_n    (hwstby_n),
   .osc_en      (osc_en),
   .clk_gate_en (clk_gate_en),
   .periph_rst  (periph_rst),
   .irq_start   (irq_start),
   .rst_start   (rst_start),
   .hw_stby     (hw_stby),
   .stby_en_q   (stby_en_q),
   .wdt_en_q    (wdt_en_q)
);

// File: tb/stby_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module stby_pwr_ctrl_tb_top;

   localparam int N_IRQ = 3;

   logic             clk = 1'b0;
   logic             por_n;
   logic             sleep_req, stby_en_wr, stby_en_d, wdt_en_wr, wdt_en_d, wdt_wd_mode;
   logic [2:0]       settle_sel;
   logic             nmi;
   logic [N_IRQ-1:0] irq_req, irq_en;
   logic             irq_mask, res_n, hwstby_n;
   logic             osc_en, clk_gate_en, periph_rst, irq_start, rst_start, hw_stby;
   logic             stby_en_q, wdt_en_q;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   stby_pwr_ctrl #(.N_IRQ(N_IRQ)) dut_i (
      .clk(clk), .por_n(por_n), .sleep_req(sleep_req),
      .stby_en_wr(stby_en_wr), .stby_en_d(stby_en_d),
      .wdt_en_wr(wdt_en_wr), .wdt_en_d(wdt_en_d), .wdt_wd_mode(wdt_wd_mode),
      .settle_sel(settle_sel), .nmi(nmi), .irq_req(irq_req), .irq_en(irq_en),
      .irq_mask(irq_mask), .res_n(res_n), .hwstby_n(hwstby_n),
      .osc_en(osc_en), .clk_gate_en(clk_gate_en), .periph_rst(periph_rst),
      .irq_start(irq_start), .rst_start(rst_start), .hw_stby(hw_stby),
      .stby_en_q(stby_en_q), .wdt_en_q(wdt_en_q)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input bit wr_s, input bit d_s, input bit wr_w, input bit d_w);
      stby_en_wr = wr_s; stby_en_d = d_s; wdt_en_wr = wr_w; wdt_en_d = d_w;
      @(negedge clk);
      stby_en_wr = 1'b0; wdt_en_wr = 1'b0;
   endtask

   task automatic enter_standby();
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
   endtask

   // Wake source already driven at the current negedge; count gated settling cycles.
   task automatic measure_settle(output int n, output int strobe_seen);
      n = 0;
      strobe_seen = 0;
      @(negedge clk);
      while (!clk_gate_en && n < 140000) begin
         if (!osc_en) n = n + 200000;
         n++;
         @(negedge clk);
      end
      strobe_seen = int'(irq_start);
   endtask

   task automatic t_reset();
      chk("R12", "osc_en", int'(osc_en), 1);
      chk("R12", "clk_gate_en", int'(clk_gate_en), 1);
      chk("R12", "periph_rst", int'(periph_rst), 0);
      chk("R12", "hw_stby", int'(hw_stby), 0);
      chk("R12", "strobes", int'(irq_start | rst_start), 0);
      chk("R12", "enable bits", int'({stby_en_q, wdt_en_q}), 0);
   endtask

   task automatic t_config();
      wdt_wd_mode = 1'b1;
      cfg_write(0, 0, 1, 1);
      chk("R10", "wdt accepted", int'(wdt_en_q), 1);
      cfg_write(1, 1, 0, 0);
      chk("R10", "stby refused", int'(stby_en_q), 0);
      cfg_write(0, 0, 1, 0);
      cfg_write(1, 1, 0, 0);
      chk("R10", "stby accepted", int'(stby_en_q), 1);
      cfg_write(0, 0, 1, 1);
      chk("R10", "wdt refused", int'(wdt_en_q), 0);
      cfg_write(1, 0, 0, 0);
      cfg_write(1, 1, 1, 1);
      chk("R10", "simultaneous", int'({stby_en_q, wdt_en_q}), 1);
      cfg_write(0, 0, 1, 0);
      wdt_wd_mode = 1'b0;
      cfg_write(0, 0, 1, 1);
      cfg_write(1, 1, 0, 0);
      chk("R10", "interval mode both", int'({stby_en_q, wdt_en_q}), 3);
      cfg_write(0, 0, 1, 0);
      cfg_write(1, 0, 0, 0);
   endtask

   task automatic t_sleep_disabled();
      enter_standby();
      repeat (3) @(negedge clk);
      chk("R1", "gate after sleep with enable 0", int'(clk_gate_en), 1);
      chk("R1", "periph_rst after sleep with enable 0", int'(periph_rst), 0);
      cfg_write(1, 1, 0, 0);
   endtask

   task automatic t_nmi_wake();
      int n, s;
      settle_sel = 3'd5;
      irq_mask = 1'b1;
      enter_standby();
      chk("R2", "standby outputs", int'({osc_en, clk_gate_en, periph_rst}), 1);
      chk("R1", "standby entered", int'(hw_stby), 0);
      nmi = 1'b1;
      measure_settle(n, s);
      nmi = 1'b0;
      chk("R4", "code 5 settle", n, 1024);
      chk("R5", "irq_start at first run cycle", s, 1);
      @(negedge clk);
      chk("R5", "irq_start one cycle", int'(irq_start), 0);
      irq_mask = 1'b0;
   endtask

   task automatic t_irq_qual();
      int n, s;
      settle_sel = 3'd6;
      enter_standby();
      irq_req = 3'b010; irq_en = 3'b101;
      repeat (20) @(negedge clk);
      chk("R3", "disabled request ignored", int'(osc_en), 0);
      irq_en = 3'b010; irq_mask = 1'b1;
      repeat (20) @(negedge clk);
      chk("R3", "masked request ignored", int'(osc_en), 0);
      irq_mask = 1'b0;
      measure_settle(n, s);
      irq_req = '0; irq_en = '0;
      chk("R4", "code 6 settle via irq", n, 2048);
      chk("R5", "irq_start after irq wake", s, 1);
   endtask

   task automatic t_code(input logic [2:0] code, input int exp);
      int n, s;
      settle_sel = code;
      enter_standby();
      nmi = 1'b1;
      measure_settle(n, s);
      nmi = 1'b0;
      chk("R4", $sformatf("code %0d settle", code), n, exp);
   endtask

   task automatic t_restart();
      int n, s;
      settle_sel = 3'd5;
      enter_standby();
      nmi = 1'b1;
      @(negedge clk);
      nmi = 1'b0;
      repeat (299) @(negedge clk);
      chk("R6", "still settling before restart", int'(clk_gate_en), 0);
      nmi = 1'b1;
      measure_settle(n, s);
      nmi = 1'b0;
      chk("R6", "settle after restart edge", n, 1024);
   endtask

   task automatic t_reset_abort();
      int seen = 0;
      settle_sel = 3'd0;
      enter_standby();
      nmi = 1'b1;
      @(negedge clk);
      nmi = 1'b0;
      repeat (50) @(negedge clk);
      res_n = 1'b0;
      @(negedge clk);
      chk("R7", "clocks on at reset", int'({osc_en, clk_gate_en, periph_rst}), 7);
      repeat (10) begin
         @(negedge clk);
         seen |= int'(rst_start | irq_start);
      end
      chk("R7", "no strobe while reset low", seen, 0);
      res_n = 1'b1;
      @(negedge clk);
      chk("R7", "rst_start after release", int'(rst_start), 1);
      chk("R7", "running after release", int'(periph_rst), 0);
      seen = 0;
      repeat (20) begin
         @(negedge clk);
         seen |= int'(rst_start | irq_start);
      end
      chk("R7", "settling aborted, no later strobe", seen, 0);
   endtask

   task automatic t_hw_standby();
      int seen = 0;
      settle_sel = 3'd5;
      enter_standby();
      nmi = 1'b1;
      @(negedge clk);
      nmi = 1'b0;
      repeat (10) @(negedge clk);
      hwstby_n = 1'b0;
      @(negedge clk);
      chk("R8", "hw standby from settling", int'({hw_stby, osc_en, clk_gate_en}), 4);
      hwstby_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R9", "stays in hw standby with reset high", int'(hw_stby), 1);
      res_n = 1'b0;
      @(negedge clk);
      chk("R9", "reset hold after hw standby", int'({hw_stby, clk_gate_en}), 1);
      res_n = 1'b1;
      @(negedge clk);
      chk("R7", "rst_start after hw standby", int'(rst_start), 1);
      repeat (1100) begin
         @(negedge clk);
         seen |= int'(irq_start);
      end
      chk("R8", "aborted settling gives no irq_start", seen, 0);
      hwstby_n = 1'b0;
      @(negedge clk);
      chk("R8", "hw standby from run", int'({hw_stby, osc_en, clk_gate_en, periph_rst}), 9);
      res_n = 1'b0; hwstby_n = 1'b1;
      @(negedge clk);
      res_n = 1'b1;
      @(negedge clk);
      chk("R11", "rst_start with gate open", int'(rst_start & clk_gate_en), 1);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      por_n = 1'b0; sleep_req = 0; stby_en_wr = 0; stby_en_d = 0;
      wdt_en_wr = 0; wdt_en_d = 0; wdt_wd_mode = 0; settle_sel = 3'd5;
      nmi = 0; irq_req = '0; irq_en = '0; irq_mask = 0; res_n = 1; hwstby_n = 1;
      repeat (4) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_config();
      t_sleep_disabled();
      t_nmi_wake();
      t_irq_qual();
      t_code(3'd7, 2048);
      t_code(3'd0, 8192);
      t_restart();
      t_reset_abort();
      t_hw_standby();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule